// File: doc/BRIEF.md
# Folded Interleaver Address Map for Parallel Soft Decoders

This block holds the interleaver address table that lets several soft-in soft-out decoders work side by side on one code block. The data memory next to it is folded: a block of K = LANES x R symbols sits in R rows, with LANES symbols in each row. Symbol j is in row j mod R, lane j div R. During loading, a single serial address generator delivers the interleaved index of each natural position in turn. The block packs these indices into R words of LANES fields each. Index number i goes to field i div R of word i mod R. Each field is filled by merging into the word that was read on the previous cycle.

During a half-iteration the decoders step through rows in natural order. For each requested word the block returns one row address for the folded data memory, taken as the smallest index in the word. It also returns two lane maps. The gather map tells each decoder which lane of the fetched row carries its interleaved input. The scatter map tells each data-memory lane which decoder supplies the value to write back when deinterleaving. Because a quadratic permutation interleaver keeps all LANES indices of a word in one row, one row fetch and a small crossbar replace LANES separate interleavers. Two banks alternate roles, so the next block's table can be loaded while the current one is read.

Top module: `ilv_fold_map`

## Requirements
- R1: After a completed load, field d of word n holds the load value with sequence number d*R + n, where values are numbered from 0 in arrival order. Field d is exposed as lane d of the output maps.
- R2: With R = 1, every load value writes the same word, and the fields written earlier in that word keep their values.
- R3: `out_valid` is high exactly two rising edges after the edge that samples `rd_en` high and is low otherwise. With it, `out_row` equals the smallest index in the addressed word, which equals each index of the word mod R.
- R4: With `out_valid`, bits [3d+2:3d] of `out_gsel` (LANES = 8) equal field d's index div R. These bits name the data-memory lane that decoder d reads.
- R5: With `out_valid`, bits [3m+2:3m] of `out_ssel` give the decoder d whose gather lane is m. The scatter map is the inverse of the gather map.
- R6: A load goes only to the bank not selected for reading. Reads of the selected bank return the same results before, during and after that load. A pulse on `dec_swap` makes the last loaded table the one that is read.
- R7: `ld_done` is a one-cycle pulse, raised after the edge that accepts value number LANES*R - 1. `ld_valid` while no load is in progress writes nothing.
- R8: Under reset, `out_valid`, `ld_busy` and `ld_done` are low.
- R9: R is taken from `cfg_rows` at `ld_start`, any value from 1 to ROWS_MAX, and stays with the table when it is swapped in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rows | input | RC_W (7) | Rows R of the block to load, sampled at `ld_start` |
| ld_start | input | 1 | Begins a load into the idle bank |
| ld_valid | input | 1 | An interleaved index is presented |
| ld_idx | input | IDX_W (9) | Interleaved index for the next natural position |
| ld_busy | output | 1 | A load is in progress |
| ld_done | output | 1 | Pulse when the last index has been stored |
| dec_swap | input | 1 | Makes the last loaded bank the read bank |
| rd_en | input | 1 | Read request for one word |
| rd_addr | input | AW (6) | Natural row to read |
| out_valid | output | 1 | Map outputs valid |
| out_row | output | AW (6) | Row address for the folded data memory |
| out_gsel | output | LANES*LANE_W (24) | Per-decoder source lane (gather) |
| out_ssel | output | LANES*LANE_W (24) | Per-memory-lane source decoder (scatter) |

## Verification
The hardest case to reach is a load running against a read, because both banks are active at once and a wrong bank choice corrupts only the table being read. The bench forks a long load next to repeated reads of the swapped-in table. It checks each of those reads against the old reference before any swap. The other hard case is the read-modify-write collision at R = 1, where each cycle merges into the word written on the previous cycle. A directed block with R = 1 and load values delivered back to back covers it. Random folded permutations with random R, and loads with random idle gaps, cover the rest, including R = ROWS_MAX.

// File: rtl/ilv_pkg.sv
// Shared constants for the folded interleaver address map.
// Assumes LANES is a power of two of at least 2.
package ilv_pkg;
    parameter int ILV_BANKS    = 2;  // ping-pong table banks
    parameter int ILV_LANES    = 8;  // default parallel decoder count
    parameter int ILV_ROWS_MAX = 64; // default largest rows per block
endpackage

// File: rtl/ilv_bank_ram.sv
// One table bank: a single write port and a synchronous read port.
// When a read and a write hit the same address in one cycle, the read returns the new data.
// Assumes DEPTH <= 2**AW.
module ilv_bank_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 72,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Storage write and registered read with write-first forwarding.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (we && (waddr == raddr))
            rdata <= wdata;
        else
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/ilv_pack_loader.sv
// Packs a serial stream of interleaved indices into R words of LANES fields.
// Index number i goes to field i div R of word i mod R.
// The word to be written next is always the one read on the previous cycle,
// so each write merges one field into the prior contents.
// Assumes the caller routes rd_addr and wr_* to the idle bank.
module ilv_pack_loader #(
    parameter int LANES  = 8,
    parameter int IDX_W  = 9,
    parameter int AW     = 6,
    parameter int RC_W   = 7,
    parameter int LANE_W = 3,
    localparam int WW    = LANES * IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_start,
    input  logic [RC_W-1:0]  cfg_rows,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [WW-1:0]    old_word,
    output logic             busy,
    output logic             done,
    output logic [RC_W-1:0]  rows_q,
    output logic [AW-1:0]    rd_addr,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [WW-1:0]    wr_data
);
    logic [AW-1:0]     row_q;
    logic [LANE_W-1:0] fld_q;
    logic              last_row;
    logic [AW-1:0]     row_nxt;

    // Position bookkeeping for the current write.
    always_comb begin
        last_row = (RC_W'(row_q) == (rows_q - RC_W'(1)));
        row_nxt  = last_row ? '0 : row_q + AW'(1);
        wr_en    = busy && ld_valid;
        wr_addr  = row_q;
        rd_addr  = ld_start ? '0 : (wr_en ? row_nxt : row_q);
    end

    // Merge the incoming index into the selected field of the prior word.
    always_comb begin
        wr_data = old_word;
        for (int f = 0; f < LANES; f++)
            if (fld_q == LANE_W'(f))
                wr_data[f*IDX_W +: IDX_W] = ld_idx;
    end

    // Row and field counters, plus the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            row_q  <= '0;
            fld_q  <= '0;
            rows_q <= RC_W'(1);
        end else begin
            done <= 1'b0;
            if (ld_start) begin
                busy   <= 1'b1;
                row_q  <= '0;
                fld_q  <= '0;
                rows_q <= cfg_rows;
            end else if (wr_en) begin
                row_q <= row_nxt;
                if (last_row) begin
                    if (fld_q == LANE_W'(LANES - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        fld_q <= fld_q + LANE_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ilv_lane_route.sv
// Turns one packed word into a folded-memory row and the two lane crossbar maps.
// Field d holds index v. Its lane is v div R, found by comparing v against the
// multiples of R, with no divider. The row is the smallest index in the word.
// Assumes every index in the word is below LANES*R and all fields share one row.
module ilv_lane_route #(
    parameter int LANES  = 8,
    parameter int IDX_W  = 9,
    parameter int AW     = 6,
    parameter int RC_W   = 7,
    parameter int LANE_W = 3,
    localparam int WW    = LANES * IDX_W
) (
    input  logic [WW-1:0]            word,
    input  logic [RC_W-1:0]          rows,
    output logic [AW-1:0]            row_out,
    output logic [LANES*LANE_W-1:0]  gsel,
    output logic [LANES*LANE_W-1:0]  ssel
);
    logic [IDX_W-1:0]  thr  [LANES];
    logic [LANE_W-1:0] lane [LANES];
    logic [IDX_W-1:0]  vmin;

    // Lane boundaries: j*R for j = 0 .. LANES-1.
    always_comb begin
        for (int j = 0; j < LANES; j++)
            thr[j] = IDX_W'(j) * IDX_W'(rows);
    end

    // Lane of each field: the last boundary not above its index.
    always_comb begin
        for (int d = 0; d < LANES; d++) begin
            lane[d] = '0;
            for (int j = 1; j < LANES; j++)
                if (word[d*IDX_W +: IDX_W] >= thr[j])
                    lane[d] = LANE_W'(j);
            gsel[d*LANE_W +: LANE_W] = lane[d];
        end
    end

    // Row address: the smallest index in the word.
    always_comb begin
        vmin = word[IDX_W-1:0];
        for (int d = 1; d < LANES; d++)
            if (word[d*IDX_W +: IDX_W] < vmin)
                vmin = word[d*IDX_W +: IDX_W];
        row_out = vmin[AW-1:0];
    end

    // Scatter map: for each memory lane, the decoder whose gather lane it is.
    always_comb begin
        for (int m = 0; m < LANES; m++) begin
            ssel[m*LANE_W +: LANE_W] = '0;
            for (int d = 0; d < LANES; d++)
                if (lane[d] == LANE_W'(m))
                    ssel[m*LANE_W +: LANE_W] = LANE_W'(d);
        end
    end
endmodule

// File: rtl/ilv_fold_map.sv
// Top: a double-banked, folded interleaver address table with a lane crossbar map.
// A load fills the bank not selected for reading. dec_swap flips the roles.
// Reads give the row and lane maps two cycles after rd_en.
// Assumes dec_swap is not pulsed while a load or a read is in flight.
module ilv_fold_map
    import ilv_pkg::*;
#(
    parameter int LANES     = ILV_LANES,
    parameter int ROWS_MAX  = ILV_ROWS_MAX,
    localparam int LANE_W   = $clog2(LANES),
    localparam int AW       = $clog2(ROWS_MAX),
    localparam int RC_W     = $clog2(ROWS_MAX + 1),
    localparam int IDX_W    = $clog2(LANES * ROWS_MAX),
    localparam int WW       = LANES * IDX_W,
    localparam int SW       = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RC_W-1:0]   cfg_rows,
    input  logic              ld_start,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_idx,
    output logic              ld_busy,
    output logic              ld_done,
    input  logic              dec_swap,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic              out_valid,
    output logic [AW-1:0]     out_row,
    output logic [SW-1:0]     out_gsel,
    output logic [SW-1:0]     out_ssel
);
    logic            dec_bank;
    logic [RC_W-1:0] dec_rows_q;
    logic [RC_W-1:0] ld_rows_q;
    logic [AW-1:0]   ld_rd_addr;
    logic            ld_wr_en;
    logic [AW-1:0]   ld_wr_addr;
    logic [WW-1:0]   ld_wr_data;
    logic [WW-1:0]   ld_old_word;
    logic [WW-1:0]   dec_word;
    logic [WW-1:0]   bank_rd [ILV_BANKS];
    logic            s1_vld;
    logic [AW-1:0]   rt_row;
    logic [SW-1:0]   rt_gsel;
    logic [SW-1:0]   rt_ssel;

    // Read-modify-write packer feeding the idle bank.
    ilv_pack_loader #(
        .LANES(LANES), .IDX_W(IDX_W), .AW(AW), .RC_W(RC_W), .LANE_W(LANE_W)
    ) loader_i (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .cfg_rows(cfg_rows),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .old_word(ld_old_word),
        .busy(ld_busy), .done(ld_done), .rows_q(ld_rows_q),
        .rd_addr(ld_rd_addr), .wr_en(ld_wr_en), .wr_addr(ld_wr_addr),
        .wr_data(ld_wr_data)
    );

    // Two banks. Each one serves either the loader or the reader.
    for (genvar b = 0; b < ILV_BANKS; b++) begin : g_bank
        logic is_dec;
        assign is_dec = (dec_bank == 1'(b));
        ilv_bank_ram #(.DEPTH(ROWS_MAX), .WIDTH(WW), .AW(AW)) ram_i (
            .clk(clk),
            .we(ld_wr_en && !is_dec),
            .waddr(ld_wr_addr),
            .wdata(ld_wr_data),
            .raddr(is_dec ? rd_addr : ld_rd_addr),
            .rdata(bank_rd[b])
        );
    end

    // Steer the bank outputs to their current users.
    always_comb begin
        dec_word    = dec_bank ? bank_rd[1] : bank_rd[0];
        ld_old_word = dec_bank ? bank_rd[0] : bank_rd[1];
    end

    // Bank role and the block size that travels with the read bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_bank   <= 1'b0;
            dec_rows_q <= RC_W'(1);
        end else if (dec_swap) begin
            dec_bank   <= !dec_bank;
            dec_rows_q <= ld_rows_q;
        end
    end

    // Row and crossbar maps from the fetched word.
    ilv_lane_route #(
        .LANES(LANES), .IDX_W(IDX_W), .AW(AW), .RC_W(RC_W), .LANE_W(LANE_W)
    ) route_i (
        .word(dec_word), .rows(dec_rows_q),
        .row_out(rt_row), .gsel(rt_gsel), .ssel(rt_ssel)
    );

    // Two-stage read pipeline: RAM fetch, then registered maps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld    <= 1'b0;
            out_valid <= 1'b0;
            out_row   <= '0;
            out_gsel  <= '0;
            out_ssel  <= '0;
        end else begin
            s1_vld    <= rd_en;
            out_valid <= s1_vld;
            if (s1_vld) begin
                out_row  <= rt_row;
                out_gsel <= rt_gsel;
                out_ssel <= rt_ssel;
            end
        end
    end
endmodule

// File: rtl/ilv_fold_map_chk.sv
// Property checker for ilv_fold_map, attached through bind.
// Assumes the table being read was filled with a folded permutation.
module ilv_fold_map_chk #(
    parameter int LANES  = 8,
    parameter int LANE_W = 3,
    parameter int AW     = 6,
    parameter int RC_W   = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_en,
    input logic                    out_valid,
    input logic [AW-1:0]           out_row,
    input logic [RC_W-1:0]         dec_rows,
    input logic [LANES*LANE_W-1:0] out_gsel,
    input logic [LANES*LANE_W-1:0] out_ssel,
    input logic                    ld_done,
    input logic                    ld_busy,
    input logic                    wr_en
);
    logic [LANES-1:0] gmask;
    logic             inv_ok;

    // Lane coverage of the gather map and its agreement with the scatter map.
    always_comb begin
        gmask  = '0;
        inv_ok = 1'b1;
        for (int d = 0; d < LANES; d++)
            gmask[out_gsel[d*LANE_W +: LANE_W]] = 1'b1;
        for (int m = 0; m < LANES; m++)
            if (out_gsel[int'(out_ssel[m*LANE_W +: LANE_W])*LANE_W +: LANE_W] != LANE_W'(m))
                inv_ok = 1'b0;
    end

    p_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 out_valid);
    p_nospur_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rd_en, 2));
    p_row_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (RC_W'(out_row) < dec_rows));
    p_gather_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (gmask == {LANES{1'b1}}));
    p_scatter_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inv_ok);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !ld_done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> !ld_busy);
    p_idle_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_busy |-> !wr_en);
endmodule

bind ilv_fold_map ilv_fold_map_chk #(
    .LANES(LANES), .LANE_W(LANE_W), .AW(AW), .RC_W(RC_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .out_valid(out_valid),
    .out_row(out_row), .dec_rows(dec_rows_q), .out_gsel(out_gsel),
    .out_ssel(out_ssel), .ld_done(ld_done), .ld_busy(ld_busy),
    .wr_en(ld_wr_en)
);

// File: tb/ilv_fold_map_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: quadratic-permutation and random folded tables, checked
// against a reference gather and scatter on an emulated folded data memory.
module ilv_fold_map_tb_top;
    localparam int LANES    = 8;
    localparam int ROWS_MAX = 64;
    localparam int LANE_W   = $clog2(LANES);
    localparam int AW       = $clog2(ROWS_MAX);
    localparam int RC_W     = $clog2(ROWS_MAX + 1);
    localparam int IDX_W    = $clog2(LANES * ROWS_MAX);
    localparam int SW       = LANES * LANE_W;
    localparam int KMAX     = LANES * ROWS_MAX;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RC_W-1:0]   cfg_rows = '0;
    logic              ld_start = 1'b0;
    logic              ld_valid = 1'b0;
    logic [IDX_W-1:0]  ld_idx = '0;
    logic              ld_busy;
    logic              ld_done;
    logic              dec_swap = 1'b0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              out_valid;
    logic [AW-1:0]     out_row;
    logic [SW-1:0]     out_gsel;
    logic [SW-1:0]     out_ssel;

    int checks = 0;
    int errors = 0;
    int perm_cur [KMAX];
    int perm_nxt [KMAX];
    int cur_r = 1;
    int nxt_r = 1;
    int seed_v;

    always #2.5 clk = ~clk;

    ilv_fold_map #(.LANES(LANES), .ROWS_MAX(ROWS_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .ld_start(ld_start),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_busy(ld_busy),
        .ld_done(ld_done), .dec_swap(dec_swap), .rd_en(rd_en),
        .rd_addr(rd_addr), .out_valid(out_valid), .out_row(out_row),
        .out_gsel(out_gsel), .out_ssel(out_ssel)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Emulated folded data memory: lane m of row r holds symbol m*R + r.
    function automatic int data_at(input int row, input int lane, input int r);
        return (lane * r + row) * 3 + 5;
    endfunction

    task automatic gen_qpp(input int k, input int f1, input int f2);
        nxt_r = k / LANES;
        for (int i = 0; i < k; i++)
            perm_nxt[i] = int'((longint'(f1) * i + longint'(f2) * i * i) % k);
    endtask

    // Random folded permutation: one row map, a fresh lane shuffle per word.
    task automatic gen_rand(input int r);
        int rowmap [ROWS_MAX];
        int lp [LANES];
        nxt_r = r;
        for (int n = 0; n < r; n++) rowmap[n] = n;
        for (int n = r - 1; n > 0; n--) begin
            int j = int'($urandom % (n + 1));
            int t = rowmap[n]; rowmap[n] = rowmap[j]; rowmap[j] = t;
        end
        for (int n = 0; n < r; n++) begin
            for (int d = 0; d < LANES; d++) lp[d] = d;
            for (int d = LANES - 1; d > 0; d--) begin
                int j = int'($urandom % (d + 1));
                int t = lp[d]; lp[d] = lp[j]; lp[j] = t;
            end
            for (int d = 0; d < LANES; d++)
                perm_nxt[d * r + n] = lp[d] * r + rowmap[n];
        end
    endtask

    // Stream perm_nxt in, with optional idle gaps, then send stray values.
    task automatic load_block(input bit gaps);
        @(negedge clk);
        cfg_rows = RC_W'(nxt_r);
        ld_start = 1'b1;
        @(negedge clk);
        ld_start = 1'b0;
        for (int i = 0; i < nxt_r * LANES; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                ld_valid = 1'b0;
                @(negedge clk);
            end
            ld_valid = 1'b1;
            ld_idx   = IDX_W'(perm_nxt[i]);
            @(negedge clk);
        end
        ld_valid = 1'b0;
        chk(ld_done == 1'b1, "R7 done pulse", int'(ld_done), 1);
        chk(ld_busy == 1'b0, "R7 idle after done", int'(ld_busy), 0);
        @(negedge clk);
        chk(ld_done == 1'b0, "R7 done single cycle", int'(ld_done), 0);
        for (int s = 0; s < 3; s++) begin
            ld_valid = 1'b1;
            ld_idx   = IDX_W'($urandom);
            @(negedge clk);
        end
        ld_valid = 1'b0;
    endtask

    task automatic do_swap();
        @(negedge clk);
        dec_swap = 1'b1;
        @(negedge clk);
        dec_swap = 1'b0;
        for (int i = 0; i < KMAX; i++) perm_cur[i] = perm_nxt[i];
        cur_r = nxt_r;
    endtask

    // Read word n and compare all maps with the reference table.
    task automatic check_word(input int n, input string ctx);
        int  erow, gact, gexp, sact, sexp;
        bit  gok, sok;
        @(negedge clk);
        rd_addr = AW'(n);
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(out_valid == 1'b0, {ctx, " R3 latency early"}, int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, {ctx, " R3 latency"}, int'(out_valid), 1);
        erow = perm_cur[n] % cur_r;
        chk(int'(out_row) == erow, {ctx, " R3 row"}, int'(out_row), erow);
        gok = 1'b1; gact = 0; gexp = 0;
        for (int d = 0; d < LANES; d++) begin
            int got = data_at(int'(out_row), int'(out_gsel[d*LANE_W +: LANE_W]), cur_r);
            int exp = perm_cur[d * cur_r + n] * 3 + 5;
            if (gok && got != exp) begin gok = 1'b0; gact = got; gexp = exp; end
        end
        chk(gok, {ctx, " R1 R4 gather"}, gact, gexp);
        sok = 1'b1; sact = 0; sexp = 0;
        for (int m = 0; m < LANES; m++) begin
            int dd  = int'(out_ssel[m*LANE_W +: LANE_W]);
            int got = perm_cur[dd * cur_r + n];
            int exp = m * cur_r + erow;
            if (sok && got != exp) begin sok = 1'b0; sact = got; sexp = exp; end
        end
        chk(sok, {ctx, " R5 scatter"}, sact, sexp);
    endtask

    task automatic check_all(input string ctx);
        for (int n = 0; n < cur_r; n++) check_word(n, ctx);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed_v = $urandom(32'h1F0D);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
        chk(ld_busy == 1'b0, "R8 reset busy", int'(ld_busy), 0);
        chk(ld_done == 1'b0, "R8 reset done", int'(ld_done), 0);
        rst_n = 1'b1;

        // K = 40: five rows, the small reference case.
        gen_qpp(40, 3, 10);
        load_block(1'b0);
        do_swap();
        check_all("K40");

        // R6: load K = 256 while repeatedly reading the K = 40 table.
        gen_qpp(256, 15, 32);
        fork
            load_block(1'b1);
            for (int rep = 0; rep < 12; rep++) check_all("R6 during load");
        join
        check_all("R6 after load");
        do_swap();
        check_all("K256");

        // R2: one row, every write merges into the same word.
        gen_qpp(8, 3, 0);
        load_block(1'b0);
        do_swap();
        check_all("R2 one row");

        // R9: the largest row count.
        gen_qpp(512, 31, 64);
        load_block(1'b1);
        do_swap();
        check_all("R9 max rows");

        // Random folded permutations with random row counts.
        for (int it = 0; it < 5; it++) begin
            gen_rand(1 + int'($urandom % ROWS_MAX));
            load_block(1'b1);
            check_word(0, "R6 before swap");
            do_swap();
            check_all("R9 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule